// File: doc/BRIEF.md
# Read-Sequence Save/Restore Command Detector

This block sits beside a byte-wide memory and watches the accesses that the memory completes. Every access reaches it as a one-cycle strobe with an 11-bit address and a flag that marks a write. A host asks for a nonvolatile save or a nonvolatile restore by making six reads in a row from fixed addresses. The first five reads are the same for both commands. The sixth read picks the command. When the block sees a complete, clean sequence, it raises a one-cycle request toward the transfer engine.

Progress is lost on any write, on any read that is not the next expected address, and on a read of the reserved test address in the last position. A read of address 0x000 always counts as the first step of a new attempt, even when it is the access that ends an older one. The transfer engine drives a busy input. A sequence that completes while busy is high is consumed and no request is issued.

Top module: `nvcmd_seq_detect`

## Requirements
- R1: A synchronous active-high reset returns the progress to idle and holds both requests low. After reset, the last five steps on their own produce no request.
- R2: The reads 0x000, 0x555, 0x2AA, 0x7FF, 0x0F0 and then 0x70F, all with the write flag low, produce `store_req` high for exactly the one cycle after the sixth strobe is sampled.
- R3: The same five-read prefix followed by a read of 0x70E produces `recall_req` high for exactly the one cycle after the sixth strobe is sampled.
- R4: A sixth read of 0x39C, or of any address other than 0x70F or 0x70E, issues no request and discards the progress. A following lone 0x70F read does nothing.
- R5: A strobe with the write flag high aborts the sequence at any step, including the sixth step and a write to the expected address, and never issues a request.
- R6: A read of any address other than the next expected one aborts the sequence, whether the address is foreign or belongs to the sequence out of order.
- R7: A read of 0x000 that aborts a sequence, or that repeats the first step, is taken as step one of a new attempt.
- R8: Cycles without a strobe do not change the progress, however many of them fall between steps.
- R9: If `xfer_busy` is high in the cycle the sixth strobe is sampled, no request is issued and the progress returns to idle.
- R10: `store_req` and `recall_req` are never high together and never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_vld | input | 1 | One-cycle strobe marking a completed access |
| acc_addr | input | 11 | Address of the completed access |
| acc_wr | input | 1 | High when the access was a write |
| xfer_busy | input | 1 | Transfer engine busy; suppresses requests |
| store_req | output | 1 | One-cycle save request |
| recall_req | output | 1 | One-cycle restore request |

## Verification
The bench runs clean store and recall sequences, with and without idle gaps, to tell the two terminal addresses apart and to show that gaps do not count as steps. It then breaks the sequence in several ways: a write at an inner step and at the final step, a foreign read, a sequence read out of order, the reserved test terminal, busy at completion, and a reset partway through. Each of these must yield no request. Sequences that recover through a repeated or aborting 0x000 must still fire, which separates a correct restart from a plain return to idle. A behavioural model built on a plain step counter is compared with both outputs on every clock.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;
    localparam int ADDR_W     = 11;
    localparam int PREFIX_LEN = 5;
    localparam int CNT_W      = $clog2(PREFIX_LEN + 1);

    localparam logic [ADDR_W-1:0] PREFIX_ADDR [PREFIX_LEN] = '{
        11'h000, 11'h555, 11'h2AA, 11'h7FF, 11'h0F0
    };
    localparam logic [ADDR_W-1:0] STORE_ADDR  = 11'h70F;
    localparam logic [ADDR_W-1:0] RECALL_ADDR = 11'h70E;
    localparam logic [ADDR_W-1:0] TEST_ADDR   = 11'h39C;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_STORE  = 2'd1,
        CMD_RECALL = 2'd2
    } cmd_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } trk_t;

    typedef struct packed {
        logic store;
        logic recall;
    } req_t;
endpackage

// File: rtl/nvcmd_addr_class.sv
module nvcmd_addr_class
    import nvcmd_pkg::*;
(
    input  logic [ADDR_W-1:0]     addr,
    output logic [PREFIX_LEN-1:0] prefix_hit,
    output cmd_e                  term_cmd
);
    // one comparator per prefix step
    for (genvar g = 0; g < PREFIX_LEN; g++) begin : g_prefix
        assign prefix_hit[g] = (addr == PREFIX_ADDR[g]);
    end

    always_comb begin
        if (addr == STORE_ADDR) begin
            term_cmd = CMD_STORE;
        end else if (addr == RECALL_ADDR) begin
            term_cmd = CMD_RECALL;
        end else if (addr == TEST_ADDR) begin
            // reserved terminal: explicitly never a command here
            term_cmd = CMD_NONE;
        end else begin
            term_cmd = CMD_NONE;
        end
    end
endmodule

// File: rtl/nvcmd_seq_track.sv
module nvcmd_seq_track
    import nvcmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_vld,
    input  logic                  acc_wr,
    input  logic [PREFIX_LEN-1:0] prefix_hit,
    input  cmd_e                  term_cmd,
    output cmd_e                  done_cmd,
    output logic [CNT_W-1:0]      cnt
);
    trk_t trk_d, trk_q;
    logic expect_hit;
    logic [CNT_W-1:0] restart_cnt;

    always_comb begin
        expect_hit = 1'b0;
        for (int i = 0; i < PREFIX_LEN; i++) begin
            if (trk_q.cnt == CNT_W'(i)) begin
                expect_hit = prefix_hit[i];
            end
        end
        // an access to the first prefix address starts a new attempt
        restart_cnt = prefix_hit[0] ? CNT_W'(1) : '0;

        trk_d    = trk_q;
        done_cmd = CMD_NONE;
        if (acc_vld) begin
            if (acc_wr) begin
                trk_d.cnt = '0;
            end else if (trk_q.cnt == CNT_W'(PREFIX_LEN)) begin
                done_cmd  = term_cmd;
                trk_d.cnt = restart_cnt;
            end else if (expect_hit) begin
                trk_d.cnt = trk_q.cnt + CNT_W'(1);
            end else begin
                trk_d.cnt = restart_cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign cnt = trk_q.cnt;
endmodule

// File: rtl/nvcmd_req_pulse.sv
module nvcmd_req_pulse
    import nvcmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_e done_cmd,
    input  logic busy,
    output logic store_req,
    output logic recall_req
);
    req_t req_d, req_q;

    always_comb begin
        req_d.store  = (done_cmd == CMD_STORE)  && !busy;
        req_d.recall = (done_cmd == CMD_RECALL) && !busy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign store_req  = req_q.store;
    assign recall_req = req_q.recall;
endmodule

// File: rtl/nvcmd_seq_detect.sv
module nvcmd_seq_detect
    import nvcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_vld,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic              xfer_busy,
    output logic              store_req,
    output logic              recall_req
);
    logic [PREFIX_LEN-1:0] prefix_hit;
    cmd_e                  term_cmd;
    cmd_e                  done_cmd;
    logic [CNT_W-1:0]      step_cnt;

    nvcmd_addr_class u_class (
        .addr       (acc_addr),
        .prefix_hit (prefix_hit),
        .term_cmd   (term_cmd)
    );

    nvcmd_seq_track u_track (
        .clk        (clk),
        .rst        (rst),
        .acc_vld    (acc_vld),
        .acc_wr     (acc_wr),
        .prefix_hit (prefix_hit),
        .term_cmd   (term_cmd),
        .done_cmd   (done_cmd),
        .cnt        (step_cnt)
    );

    nvcmd_req_pulse u_pulse (
        .clk        (clk),
        .rst        (rst),
        .done_cmd   (done_cmd),
        .busy       (xfer_busy),
        .store_req  (store_req),
        .recall_req (recall_req)
    );
endmodule

// File: rtl/nvcmd_seq_detect_chk.sv
module nvcmd_seq_detect_chk
    import nvcmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acc_vld,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_wr,
    input logic              xfer_busy,
    input logic              store_req,
    input logic              recall_req,
    input logic [CNT_W-1:0]  step_cnt
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!store_req && !recall_req && step_cnt == '0));

    // R2
    store_cause_chk: assert property (@(posedge clk) disable iff (rst)
        store_req |-> $past(acc_vld && !acc_wr && acc_addr == STORE_ADDR));

    // R3
    recall_cause_chk: assert property (@(posedge clk) disable iff (rst)
        recall_req |-> $past(acc_vld && !acc_wr && acc_addr == RECALL_ADDR));

    // R5
    write_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && acc_wr) |=> (!store_req && !recall_req && step_cnt == '0));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_vld |=> $stable(step_cnt));

    // R9
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_busy |=> (!store_req && !recall_req));

    // R10
    req_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({store_req, recall_req}));

    // R10
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        (store_req || recall_req) |=> (!store_req && !recall_req));
endmodule

bind nvcmd_seq_detect nvcmd_seq_detect_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_vld    (acc_vld),
    .acc_addr   (acc_addr),
    .acc_wr     (acc_wr),
    .xfer_busy  (xfer_busy),
    .store_req  (store_req),
    .recall_req (recall_req),
    .step_cnt   (step_cnt)
);

// File: tb/test_nvcmd_seq_detect.sv
`timescale 1ns/1ps
module test_nvcmd_seq_detect;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_vld = 1'b0;
    logic [10:0] acc_addr = '0;
    logic        acc_wr = 1'b0;
    logic        xfer_busy = 1'b0;
    logic        store_req, recall_req;

    int checks = 0;
    int errors = 0;
    int n_store = 0, n_recall = 0;
    int run_len = 0, max_run = 0;
    bit done = 0;

    always #2 clk = ~clk;

    nvcmd_seq_detect i_nvcmd_seq_detect (
        .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_addr(acc_addr),
        .acc_wr(acc_wr), .xfer_busy(xfer_busy),
        .store_req(store_req), .recall_req(recall_req)
    );

    // behavioural reference: a step index into a list of expected reads
    int unsigned want [5] = '{'h000, 'h555, 'h2AA, 'h7FF, 'h0F0};
    int  m_step = 0;
    bit  m_store = 0, m_recall = 0;

    always @(posedge clk) begin
        m_store  <= 0;
        m_recall <= 0;
        if (rst) begin
            m_step = 0;
        end else if (acc_vld) begin
            if (acc_wr) begin
                m_step = 0;
            end else if (m_step == 5) begin
                if (acc_addr == 11'h70F && !xfer_busy) m_store  <= 1;
                if (acc_addr == 11'h70E && !xfer_busy) m_recall <= 1;
                m_step = (acc_addr == 0) ? 1 : 0;
            end else if (acc_addr == want[m_step]) begin
                m_step = m_step + 1;
            end else begin
                m_step = (acc_addr == 0) ? 1 : 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // compare with the model and count pulses on every falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(store_req  == m_store,  "R2 per-cycle store",  store_req,  m_store);
            chk(recall_req == m_recall, "R3 per-cycle recall", recall_req, m_recall);
        end
        if (store_req)  n_store++;
        if (recall_req) n_recall++;
        if (store_req || recall_req) run_len++; else run_len = 0;
        if (run_len > max_run) max_run = run_len;
    end

    task automatic acc(input int a, input bit w = 0, input int gap = 0);
        @(negedge clk);
        acc_vld = 1; acc_addr = 11'(a); acc_wr = w;
        @(negedge clk);
        acc_vld = 0; acc_wr = 0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic prefix(input int gap = 0);
        acc('h000, 0, gap); acc('h555, 0, gap); acc('h2AA, 0, gap);
        acc('h7FF, 0, gap); acc('h0F0, 0, gap);
    endtask

    task automatic settle_clear();
        repeat (3) @(negedge clk);
        n_store = 0; n_recall = 0;
    endtask

    task automatic expect_counts(input string tag, input int s, input int r);
        repeat (3) @(negedge clk);
        chk(n_store == s,  {tag, " store count"},  n_store,  s);
        chk(n_recall == r, {tag, " recall count"}, n_recall, r);
        n_store = 0; n_recall = 0;
    endtask

    initial begin
        #(4 * 200000);
        chk(0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(store_req == 0 && recall_req == 0, "R1 reset outputs", {store_req, recall_req}, 0);
        rst = 0;
        settle_clear();
        // R1: tail alone after reset
        acc('h555); acc('h2AA); acc('h7FF); acc('h0F0); acc('h70F);
        expect_counts("R1 tail only", 0, 0);

        prefix(); acc('h70F);
        expect_counts("R2 store", 1, 0);
        prefix(); acc('h70E);
        expect_counts("R3 recall", 0, 1);

        prefix(); acc('h39C); acc('h70F);
        expect_counts("R4 test terminal", 0, 0);
        prefix(); acc('h123); acc('h70E);
        expect_counts("R4 foreign terminal", 0, 0);

        acc('h000); acc('h555); acc('h2AA, 1); acc('h2AA); acc('h7FF); acc('h0F0); acc('h70F);
        expect_counts("R5 inner write", 0, 0);
        prefix(); acc('h70F, 1);
        expect_counts("R5 final write", 0, 0);

        acc('h000); acc('h555); acc('h123); acc('h2AA); acc('h7FF); acc('h0F0); acc('h70F);
        expect_counts("R6 foreign read", 0, 0);
        acc('h000); acc('h2AA); acc('h555); acc('h7FF); acc('h0F0); acc('h70F);
        expect_counts("R6 out of order", 0, 0);

        acc('h000); acc('h555); prefix(); acc('h70F);
        expect_counts("R7 restart mid", 1, 0);
        acc('h000); acc('h000); acc('h555); acc('h2AA); acc('h7FF); acc('h0F0); acc('h70E);
        expect_counts("R7 repeated first", 0, 1);
        prefix(); prefix(); acc('h70E);
        expect_counts("R7 restart at sixth", 0, 1);

        prefix(4); acc('h70F, 0, 4);
        expect_counts("R8 gaps", 1, 0);

        prefix(); xfer_busy = 1; acc('h70F); xfer_busy = 0; acc('h70F);
        expect_counts("R9 busy", 0, 0);
        prefix(); acc('h70E);
        expect_counts("R9 after busy", 0, 1);

        prefix();
        @(negedge clk); rst = 1; @(negedge clk); rst = 0;
        acc('h70F);
        expect_counts("R1 mid reset", 0, 0);

        chk(max_run <= 1, "R10 pulse width", max_run, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule